// File: doc/BRIEF.md
# Two-Page Serial Display Memory Loader

This block is the write side of an on-screen character display controller. A host shifts a frame into it over a three-wire serial port: a chip select (active low), a bit clock and a data line. Bits are taken on rising bit-clock edges while chip select is low. Each frame opens with a 9-bit word address and continues with any number of 16-bit data words. The address steps forward by one after every data word.

Every data word carries a page flag in its top bit, and the word is written to page 0 or page 1. Both pages share one address range. Word addresses 0 to 287 select the character RAM. Each RAM entry holds a character code, a foreground colour, a blink bit and a background colour. Word addresses 288 to 296 select nine 15-bit display control registers. Some control bits exist only in page 0, so a page-1 write leaves them alone. An asynchronous active-low clear zeroes every control register and leaves the RAM untouched.

The register contents of both pages go out in parallel to the display logic. That logic reads the RAM through a registered read port.

Top module: `sld_loader`

## Requirements
- R1: A bit is shifted in only on a rising edge of `sck` while `cs_n` is low. Edges of `sck` while `cs_n` is high have no effect on any storage.
- R2: A frame starts with 9 address bits, most significant first. It is followed by 16-bit words, most significant first. Word bit 15 is the page flag and bits 14:0 are the payload.
- R3: After each complete data word the write address increments by one. Consecutive words in one frame land at consecutive addresses.
- R4: A word addressed to 0..287 is stored in the character RAM of its page. `rd_data` returns the entry at `rd_page`/`rd_addr` one clock after they are applied. Payload bits 7:0 are the code, 8/9/10 the red/green/blue colour, 11 the blink bit, and 12/13/14 the background red/green/blue.
- R5: A word addressed to 288+i (i = 0..8) is stored in control register i of its page. That register appears at bits [15*i+14 : 15*i] of `ctl_p0` or `ctl_p1`.
- R6: A page flag of 0 writes only page 0 and a flag of 1 writes only page 1. The copy in the other page is left unchanged.
- R7: Control registers 0 and 1 (all bits), and bit 14 of registers 2..8, exist only in page 0. A page-1 write leaves them unchanged, and they always read 0 in `ctl_p1`.
- R8: In a page-1 RAM write, code bit 7 is stored as 0, which limits page 1 to 128 characters.
- R9: A rising edge of `cs_n` discards a partly received word without a write. The next frame starts again with an address.
- R10: While `ac_n` is low, every control register of both pages reads 0, with no clock edge needed. RAM contents are not cleared.
- R11: Words addressed to 297..511 write nothing.
- R12: Each completed word produces a write strobe that lasts exactly one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, faster than twice the bit clock |
| ac_n | input | 1 | Asynchronous clear, active low |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial bit clock, sampled by `clk` |
| sin | input | 1 | Serial data |
| rd_page | input | 1 | Page selected for RAM read |
| rd_addr | input | 9 | RAM read word address |
| rd_data | output | 15 | RAM read data, one clock latency |
| ctl_p0 | output | 135 | Page-0 control registers, register i at bits 15*i upward |
| ctl_p1 | output | 135 | Page-1 control registers, same layout |

## Verification
The checks assume that `sck`, `cs_n` and `sin` are already synchronous to `clk`. They also assume that each `sck` level lasts at least two clock periods, so a word can never complete on two neighbouring cycles and the single-cycle strobe property is meaningful. The stimulus keeps every bit-clock half period at four clocks and changes `sin` and `cs_n` only while `sck` is low. It also raises `ac_n` only away from active serial traffic.

// File: rtl/sld_pkg.sv
package sld_pkg;
  localparam int SLD_ADDR_W = 9;
  localparam int SLD_DATA_W = 15;
  localparam int SLD_RAM_WORDS = 288;
  localparam int SLD_CTL_REGS = 9;
  localparam int SLD_HI_CODE_BIT = 7;

  // Bits of control register idx that exist only in page 0
  function automatic logic [SLD_DATA_W-1:0] page0_only_mask(input int idx);
    if (idx < 2) return '1;
    return {1'b1, {(SLD_DATA_W-1){1'b0}}};
  endfunction
endpackage

// File: rtl/sld_deser.sv
module sld_deser #(
  parameter int ADDR_W = 9,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              sin,
  output logic              cs_idle,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_word
);
  localparam int CNT_W = $clog2(WORD_W > ADDR_W ? WORD_W : ADDR_W);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] WORD_LAST = CNT_W'(WORD_W - 1);

  logic              cs_q, sck_q, sck_d, sin_q;
  logic              in_data_q, in_data_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [WORD_W-1:0] sh_q, sh_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic              stb_q, stb_n;
  logic [ADDR_W-1:0] stb_addr_q, stb_addr_n;
  logic [WORD_W-1:0] stb_word_q, stb_word_n;
  logic              rise;

  assign rise = sck_q & ~sck_d & ~cs_q;

  always_comb begin
    in_data_n  = in_data_q;
    cnt_n      = cnt_q;
    sh_n       = sh_q;
    addr_n     = addr_q;
    stb_n      = 1'b0;
    stb_addr_n = stb_addr_q;
    stb_word_n = stb_word_q;
    if (cs_q) begin
      in_data_n = 1'b0;
      cnt_n     = '0;
    end else if (rise) begin
      sh_n = {sh_q[WORD_W-2:0], sin_q};
      if (!in_data_q) begin
        if (cnt_q == ADDR_LAST) begin
          addr_n    = sh_n[ADDR_W-1:0];
          in_data_n = 1'b1;
          cnt_n     = '0;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end else if (cnt_q == WORD_LAST) begin
        stb_n      = 1'b1;
        stb_addr_n = addr_q;
        stb_word_n = sh_n;
        addr_n     = addr_q + 1'b1;
        cnt_n      = '0;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q       <= 1'b1;
      sck_q      <= 1'b0;
      sck_d      <= 1'b0;
      sin_q      <= 1'b0;
      in_data_q  <= 1'b0;
      cnt_q      <= '0;
      sh_q       <= '0;
      addr_q     <= '0;
      stb_q      <= 1'b0;
      stb_addr_q <= '0;
      stb_word_q <= '0;
    end else begin
      cs_q       <= cs_n;
      sck_q      <= sck;
      sck_d      <= sck_q;
      sin_q      <= sin;
      in_data_q  <= in_data_n;
      cnt_q      <= cnt_n;
      sh_q       <= sh_n;
      addr_q     <= addr_n;
      stb_q      <= stb_n;
      stb_addr_q <= stb_addr_n;
      stb_word_q <= stb_word_n;
    end
  end

  assign cs_idle = cs_q;
  assign wr_stb  = stb_q;
  assign wr_addr = stb_addr_q;
  assign wr_word = stb_word_q;
endmodule

// File: rtl/sld_ram.sv
module sld_ram #(
  parameter int ADDR_W   = 9,
  parameter int DATA_W   = 15,
  parameter int DEPTH    = 288,
  parameter int HI_BIT   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic              wr_page,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_page,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(DEPTH);

  logic [DATA_W-1:0] rd_q [2];
  logic              sel_q;
  logic              wr_ok, rd_ok;

  assign wr_ok = wr_stb && (wr_addr < LIMIT);
  assign rd_ok = rd_addr < LIMIT;

  for (genvar p = 0; p < 2; p++) begin : g_page
    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] wdata;
    if (p == 0) begin : g_full
      assign wdata = wr_data;
    end else begin : g_narrow
      assign wdata = wr_data & ~(DATA_W'(1) << HI_BIT);
    end

    always_ff @(posedge clk) begin
      if (wr_ok && (wr_page == 1'(p))) mem[wr_addr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_q[p] <= '0;
      else if (rd_ok) rd_q[p] <= mem[rd_addr];
      else            rd_q[p] <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= 1'b0;
    else        sel_q <= rd_page;
  end

  assign rd_data = rd_q[sel_q];
endmodule

// File: rtl/sld_ctl.sv
module sld_ctl
  import sld_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 15,
  parameter int NREGS  = 9,
  parameter int BASE   = 288
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_stb,
  input  logic                    wr_page,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [DATA_W-1:0]       wr_data,
  output logic [NREGS*DATA_W-1:0] ctl_p0,
  output logic [NREGS*DATA_W-1:0] ctl_p1
);
  logic [NREGS*DATA_W-1:0] flat [2];

  for (genvar p = 0; p < 2; p++) begin : g_page
    for (genvar i = 0; i < NREGS; i++) begin : g_reg
      logic [DATA_W-1:0] r_q, r_n, wmask;
      logic              we;

      if (p == 0) begin : g_all
        assign wmask = '1;
      end else begin : g_shared
        assign wmask = ~DATA_W'(page0_only_mask(i));
      end

      assign we  = wr_stb && (wr_page == 1'(p)) && (wr_addr == ADDR_W'(BASE + i));
      assign r_n = we ? ((r_q & ~wmask) | (wr_data & wmask)) : r_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_n;
      end

      assign flat[p][i*DATA_W +: DATA_W] = r_q;
    end
  end

  assign ctl_p0 = flat[0];
  assign ctl_p1 = flat[1];
endmodule

// File: rtl/sld_loader.sv
module sld_loader
  import sld_pkg::*;
#(
  parameter int ADDR_W    = SLD_ADDR_W,
  parameter int DATA_W    = SLD_DATA_W,
  parameter int RAM_WORDS = SLD_RAM_WORDS,
  parameter int CTL_REGS  = SLD_CTL_REGS,
  parameter int HI_BIT    = SLD_HI_CODE_BIT
) (
  input  logic                       clk,
  input  logic                       ac_n,
  input  logic                       cs_n,
  input  logic                       sck,
  input  logic                       sin,
  input  logic                       rd_page,
  input  logic [ADDR_W-1:0]          rd_addr,
  output logic [DATA_W-1:0]          rd_data,
  output logic [CTL_REGS*DATA_W-1:0] ctl_p0,
  output logic [CTL_REGS*DATA_W-1:0] ctl_p1
);
  localparam int WORD_W = DATA_W + 1;

  logic              rst_meta, rst_n;
  logic              cs_idle, wr_stb, wr_page;
  logic [ADDR_W-1:0] wr_addr;
  logic [WORD_W-1:0] wr_word;
  logic [DATA_W-1:0] wr_data;

  // Clear asserts at once, releases on the second clock edge
  always_ff @(posedge clk or negedge ac_n) begin
    if (!ac_n) begin
      rst_meta <= 1'b0;
      rst_n    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n    <= rst_meta;
    end
  end

  assign wr_page = wr_word[WORD_W-1];
  assign wr_data = wr_word[DATA_W-1:0];

  sld_deser #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_deser (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sin(sin),
    .cs_idle(cs_idle), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_word(wr_word)
  );

  sld_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(RAM_WORDS), .HI_BIT(HI_BIT)) u_ram (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_page(wr_page),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_page(rd_page), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  sld_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NREGS(CTL_REGS), .BASE(RAM_WORDS)) u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_page(wr_page),
    .wr_addr(wr_addr), .wr_data(wr_data), .ctl_p0(ctl_p0), .ctl_p1(ctl_p1)
  );
endmodule

// File: rtl/sld_chk.sv
module sld_chk
  import sld_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 15,
  parameter int NREGS  = 9,
  parameter int BASE   = 288
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    ac_n,
  input logic                    cs_idle,
  input logic                    wr_stb,
  input logic                    wr_page,
  input logic [ADDR_W-1:0]       wr_addr,
  input logic [DATA_W-1:0]       wr_data,
  input logic [NREGS*DATA_W-1:0] ctl_p0,
  input logic [NREGS*DATA_W-1:0] ctl_p1
);
  function automatic logic [NREGS*DATA_W-1:0] shared_flat();
    logic [NREGS*DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < NREGS; i++) m[i*DATA_W +: DATA_W] = DATA_W'(page0_only_mask(i));
    return m;
  endfunction

  localparam logic [NREGS*DATA_W-1:0] SHARED = shared_flat();

  logic              in_ctl, pend_q;
  logic [ADDR_W-1:0] rel, idx_q;
  logic [DATA_W-1:0] val_q;

  assign rel    = wr_addr - ADDR_W'(BASE);
  assign in_ctl = (wr_addr >= ADDR_W'(BASE)) && (rel < ADDR_W'(NREGS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= wr_stb && !wr_page && in_ctl;
  end

  always_ff @(posedge clk) begin
    idx_q <= rel;
    val_q <= wr_data;
  end

  // R10
  clear_zero_chk: assert property (@(posedge clk) !ac_n |-> (ctl_p0 == '0 && ctl_p1 == '0));
  // R7
  shared_p1_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) (ctl_p1 & SHARED) == '0);
  // R7
  p1_keeps_p0_chk: assert property (@(posedge clk) disable iff (!rst_n) (wr_stb && wr_page) |=> $stable(ctl_p0));
  // R5
  p0_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> (ctl_p0[DATA_W*int'(idx_q) +: DATA_W] == val_q));
  // R1
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n) cs_idle |=> !wr_stb);
  // R12
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n) wr_stb |=> !wr_stb);
endmodule

bind sld_loader sld_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NREGS(CTL_REGS), .BASE(RAM_WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ac_n(ac_n), .cs_idle(cs_idle), .wr_stb(wr_stb),
  .wr_page(wr_page), .wr_addr(wr_addr), .wr_data(wr_data), .ctl_p0(ctl_p0), .ctl_p1(ctl_p1)
);

// File: tb/sld_loader_tb.sv
module sld_loader_tb_top;
  logic         clk = 1'b0;
  logic         ac_n, cs_n, sck, sin, rd_page;
  logic [8:0]   rd_addr;
  logic [14:0]  rd_data;
  logic [134:0] ctl_p0, ctl_p1;

  int checks = 0;
  int errors = 0;
  logic [14:0] exp0 [9];
  logic [14:0] exp1 [9];
  logic [8:0]  cur_addr;

  always #5 clk = ~clk;

  sld_loader dut_i (
    .clk(clk), .ac_n(ac_n), .cs_n(cs_n), .sck(sck), .sin(sin),
    .rd_page(rd_page), .rd_addr(rd_addr), .rd_data(rd_data),
    .ctl_p0(ctl_p0), .ctl_p1(ctl_p1)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sin = b;
    wait_clk(4);
    sck = 1'b1;
    wait_clk(4);
    sck = 1'b0;
  endtask

  task automatic frame_begin(input logic [8:0] a);
    cs_n = 1'b0;
    wait_clk(2);
    for (int i = 8; i >= 0; i--) send_bit(a[i]);
    cur_addr = a;
  endtask

  // R2: page flag in bit 15, payload in bits 14:0
  task automatic send_word(input logic pg, input logic [14:0] d);
    logic [15:0] w;
    w = {pg, d};
    for (int i = 15; i >= 0; i--) send_bit(w[i]);
    if (cur_addr >= 9'd288 && cur_addr <= 9'd296) begin
      if (!pg) exp0[cur_addr - 9'd288] = d;
      else if (cur_addr >= 9'd290) exp1[cur_addr - 9'd288] = d & 15'h3FFF;
    end
    cur_addr = cur_addr + 9'd1;
  endtask

  task automatic frame_end();
    wait_clk(2);
    cs_n = 1'b1;
    wait_clk(6);
  endtask

  task automatic check_ctl(input string tag);
    int bad;
    bad = -1;
    checks++;
    for (int i = 8; i >= 0; i--) begin
      if (ctl_p0[15*i +: 15] !== exp0[i] || ctl_p1[15*i +: 15] !== exp1[i]) bad = i;
    end
    if (bad >= 0) begin
      errors++;
      $display("FAIL %s reg %0d actual p0=%h p1=%h expected p0=%h p1=%h", tag, bad,
               ctl_p0[15*bad +: 15], ctl_p1[15*bad +: 15], exp0[bad], exp1[bad]);
    end
  endtask

  task automatic check_ram(input logic pg, input logic [8:0] a, input logic [14:0] e, input string tag);
    rd_page = pg;
    rd_addr = a;
    wait_clk(2);
    checks++;
    if (rd_data !== e) begin
      errors++;
      $display("FAIL %s page %0d addr %0d actual %h expected %h", tag, pg, a, rd_data, e);
    end
  endtask

  task automatic t_reset();
    check_ctl("R10 reset state");
  endtask

  task automatic t_pages();
    frame_begin(9'd290); send_word(1'b0, 15'h1234); frame_end();
    check_ctl("R5 R6 page0 write reg2");
    frame_begin(9'd290); send_word(1'b1, 15'h0555); frame_end();
    check_ctl("R6 page1 write keeps page0");
  endtask

  task automatic t_shared();
    frame_begin(9'd289); send_word(1'b0, 15'h3ABC); frame_end();
    frame_begin(9'd289); send_word(1'b1, 15'h7FFF); frame_end();
    check_ctl("R7 page1 write to page0-only reg1");
    frame_begin(9'd291); send_word(1'b1, 15'h7FFF); frame_end();
    check_ctl("R7 page1 bit14 of reg3 stays 0");
  endtask

  task automatic t_autoinc();
    frame_begin(9'd293);
    send_word(1'b0, 15'h0A5A);
    send_word(1'b0, 15'h5A0A);
    send_word(1'b0, 15'h7001);
    frame_end();
    check_ctl("R3 R2 three words at 293..295");
  endtask

  task automatic t_ram();
    frame_begin(9'd5); send_word(1'b0, 15'h12F3); frame_end();
    frame_begin(9'd5); send_word(1'b1, 15'h12F3); frame_end();
    check_ram(1'b0, 9'd5, 15'h12F3, "R4 page0 RAM entry");
    check_ram(1'b1, 9'd5, 15'h1273, "R8 page1 code bit7 forced 0");
    frame_begin(9'd287); send_word(1'b0, 15'h6001); frame_end();
    check_ram(1'b0, 9'd287, 15'h6001, "R4 last RAM address");
    check_ram(1'b0, 9'd5, 15'h12F3, "R6 other RAM entry unchanged");
    check_ctl("R4 RAM writes leave registers");
  endtask

  task automatic t_idle_and_abort();
    sin = 1'b1;
    for (int i = 0; i < 20; i++) begin
      wait_clk(2); sck = 1'b1; wait_clk(2); sck = 1'b0;
    end
    wait_clk(4);
    check_ctl("R1 sck with cs_n high ignored");
    frame_begin(9'd292);
    for (int i = 0; i < 7; i++) send_bit(1'b1);
    frame_end();
    check_ctl("R9 partial word not written");
    frame_begin(9'd292); send_word(1'b0, 15'h0AAA); frame_end();
    check_ctl("R9 R1 next frame realigned");
  endtask

  task automatic t_range();
    frame_begin(9'd296);
    send_word(1'b0, 15'h2468);
    send_word(1'b0, 15'h7FFF);
    frame_end();
    check_ctl("R11 word beyond 296 ignored");
    frame_begin(9'd400); send_word(1'b0, 15'h7FFF); send_word(1'b1, 15'h7FFF); frame_end();
    check_ctl("R11 high address ignored");
  endtask

  task automatic t_clear();
    #3 ac_n = 1'b0;
    #2;
    checks++;
    if (ctl_p0 !== '0 || ctl_p1 !== '0) begin
      errors++;
      $display("FAIL R10 async clear actual p0=%h p1=%h expected 0", ctl_p0, ctl_p1);
    end
    for (int i = 0; i < 9; i++) begin exp0[i] = '0; exp1[i] = '0; end
    wait_clk(3);
    ac_n = 1'b1;
    wait_clk(4);
    check_ctl("R10 registers zero after clear");
    check_ram(1'b0, 9'd287, 15'h6001, "R10 RAM kept through clear");
    frame_begin(9'd288); send_word(1'b0, 15'h0101); frame_end();
    check_ctl("R5 write after clear");
  endtask

  initial begin
    ac_n = 1'b0; cs_n = 1'b1; sck = 1'b0; sin = 1'b0;
    rd_page = 1'b0; rd_addr = '0; cur_addr = '0;
    for (int i = 0; i < 9; i++) begin exp0[i] = '0; exp1[i] = '0; end
    wait_clk(3);
    t_reset();
    ac_n = 1'b1;
    wait_clk(4);
    t_pages();
    t_shared();
    t_autoinc();
    t_ram();
    t_idle_and_abort();
    t_range();
    t_clear();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule